// File: doc/BRIEF.md
# Indirect Register Host Port

This block is the host-facing register port of a stereo audio codec. A byte-wide parallel bus with a two-bit address reaches four direct locations: an index pointer, a data window into an internal file of byte registers, an interrupt status byte, and a data port for sample bytes. Only a two-bit address is needed to reach the whole register file. The host first loads the pointer, then reads or writes the window. A write to the data port hands a byte to the playback side. A read of the same address returns the byte the capture side offers and tells it to move on.

Three completion events, from playback, capture and timer, each set their own pending bit. The interrupt line is the OR of the pending bits, qualified by an enable bit in the pin-control register. The host clears pending bits either all at once, by writing the status byte, or one at a time, by writing zeros into the pending register through the window. Host reads are combinational. Writes are taken once per strobe by a small access sequencer with three named states: `ST_IDLE`, `ST_WRITE` and `ST_READ`. `ST_IDLE` goes to `ST_WRITE` when a write strobe appears, which takes the write. `ST_IDLE` goes to `ST_READ` when only a read strobe appears, which takes the read. Either busy state returns to `ST_IDLE` once its strobe drops.

Top module: `ireg_host_port`

## Requirements
- R1: After reset, the index pointer, every register byte, every pending bit and the interrupt line are zero.
- R2: A write to address 0 loads the pointer from the low 6 bits of the data byte. A read of address 0 returns the pointer, zero-extended.
- R3: Through address 1, indexes 0 and 2 to 36 are read/write storage bytes, and a read returns the last byte written there.
- R4: Address 1 reads as zero when the pointer is 37 or above, and writes made there change no register.
- R5: A write to address 3 drives the byte on `pb_data` with a one-cycle `pb_valid` pulse. A read of address 3 returns `cap_data` and raises `cap_take` for one cycle.
- R6: A strobe held for several cycles performs exactly one access. Only the first cycle of the strobe takes effect.
- R7: Each source pulse (`src_pb_done`, `src_cap_done`, `src_tmr_done`) sets its pending bit at the next clock edge. Index 1 reads pending as bit 0 playback, bit 1 capture and bit 2 timer.
- R8: `irq` and status bit 0 are high exactly when bit 0 of index 0 (the interrupt enable) is set and at least one pending bit is set. Status bits 3:1 show pending timer, capture and playback.
- R9: Writing index 1 clears each pending bit whose data bit is 0. A data bit of 1 leaves the pending bit unchanged.
- R10: Any write to address 2 clears all pending bits.
- R11: A source pulse in the same cycle as a clear leaves its pending bit set.
- R12: Storage bytes may be rewritten at any time, with no mode lock. `cfg_image` byte k shows index k from the cycle after the write is taken, and the pending slot shows zero there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 2 | Direct register select |
| host_wdata | input | 8 | Host write byte |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Host read byte, combinational |
| pb_data | output | 8 | Byte handed to playback |
| pb_valid | output | 1 | Playback byte pulse |
| cap_data | input | 8 | Byte offered by capture |
| cap_take | output | 1 | Capture byte consumed pulse |
| src_pb_done | input | 1 | Playback count expired |
| src_cap_done | input | 1 | Capture count expired |
| src_tmr_done | input | 1 | Timer expired |
| irq | output | 1 | Interrupt line |
| cfg_image | output | 296 | Flat image of all register bytes, index k at bits 8k+7:8k |

## Verification
The properties assume that address and write data stay steady while a strobe is high. They also assume a strobe is released before the next access begins, so that the one-cycle pulses on `pb_valid` and `cap_take` can never be back to back. The stimulus raises one strobe at a time, just after a clock edge, and holds its address and data for the whole strobe. It drops the strobe for at least one cycle between accesses. It raises a source pulse together with a clear only in the case that tests set-over-clear priority.

// File: rtl/ireg_pkg.sv
package ireg_pkg;

    localparam int unsigned DATA_W     = 8;
    localparam int unsigned NUM_SRC    = 3;
    localparam int unsigned PINCTL_IDX = 0;
    localparam int unsigned PEND_IDX   = 1;

    localparam logic [1:0] ADDR_PTR  = 2'd0;
    localparam logic [1:0] ADDR_WIN  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
    localparam logic [1:0] ADDR_PIO  = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } host_st_t;

endpackage

// File: rtl/ireg_access_fsm.sv
module ireg_access_fsm
    import ireg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_wr,
    input  logic host_rd,
    output logic wr_fire,
    output logic rd_fire
);

    host_st_t state_q;
    host_st_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (host_wr)      state_d = ST_WRITE;
                else if (host_rd) state_d = ST_READ;
            end
            ST_WRITE: if (!host_wr) state_d = ST_IDLE;
            ST_READ:  if (!host_rd) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // An access is taken only in the idle state, so a long strobe acts once.
    always_comb begin
        wr_fire = 1'b0;
        rd_fire = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                wr_fire = host_wr;
                rd_fire = host_rd && !host_wr;
            end
            ST_WRITE, ST_READ: begin
                wr_fire = 1'b0;
                rd_fire = 1'b0;
            end
            default: begin
                wr_fire = 1'b0;
                rd_fire = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ireg_file.sv
module ireg_file
    import ireg_pkg::*;
#(
    parameter int unsigned NREG = 37,
    parameter int unsigned IDXW = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [IDXW-1:0]        widx,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [IDXW-1:0]        ridx,
    output logic [DATA_W-1:0]      rdata,
    output logic [NREG*DATA_W-1:0] cfg_flat
);

    logic [DATA_W-1:0] slot [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        if (g == PEND_IDX) begin : g_hole
            // The pending bits live in the interrupt merger.
            assign slot[g] = '0;
        end else begin : g_store
            logic [DATA_W-1:0] byte_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                          byte_q <= '0;
                else if (we && widx == IDXW'(g))     byte_q <= wdata;
            end
            assign slot[g] = byte_q;
        end
        assign cfg_flat[g*DATA_W +: DATA_W] = slot[g];
    end

    // An index beyond the file matches no entry and reads as zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (ridx == IDXW'(i)) rdata = slot[i];
        end
    end

endmodule

// File: rtl/ireg_irq_merge.sv
module ireg_irq_merge
    import ireg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic               clr_all,
    input  logic               mask_we,
    input  logic [NUM_SRC-1:0] keep_mask,
    input  logic               ien,
    output logic [NUM_SRC-1:0] pend,
    output logic               int_flag
);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic bit_q;
        logic kept;
        always_comb begin
            kept = bit_q;
            if (clr_all)      kept = 1'b0;
            else if (mask_we) kept = bit_q & keep_mask[s];
        end
        // A new event wins over a clear in the same cycle.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= src[s] | kept;
        end
        assign pend[s] = bit_q;
    end

    assign int_flag = ien & (|pend);

endmodule

// File: rtl/ireg_host_port.sv
module ireg_host_port
    import ireg_pkg::*;
#(
    parameter int unsigned NREG = 37
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             host_addr,
    input  logic [7:0]             host_wdata,
    input  logic                   host_wr,
    input  logic                   host_rd,
    output logic [7:0]             host_rdata,
    output logic [7:0]             pb_data,
    output logic                   pb_valid,
    input  logic [7:0]             cap_data,
    output logic                   cap_take,
    input  logic                   src_pb_done,
    input  logic                   src_cap_done,
    input  logic                   src_tmr_done,
    output logic                   irq,
    output logic [NREG*DATA_W-1:0] cfg_image
);

    localparam int unsigned IDXW = $clog2(NREG);

    logic                wr_fire;
    logic                rd_fire;
    logic [IDXW-1:0]     idx_q;
    logic [DATA_W-1:0]   win_rdata;
    logic [NUM_SRC-1:0]  pend_w;
    logic                int_flag;
    logic                win_we;
    logic                pend_we;
    logic                stat_we;

    ireg_access_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .host_wr (host_wr),
        .host_rd (host_rd),
        .wr_fire (wr_fire),
        .rd_fire (rd_fire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                idx_q <= '0;
        else if (wr_fire && host_addr == ADDR_PTR) idx_q <= host_wdata[IDXW-1:0];
    end

    assign win_we  = wr_fire && (host_addr == ADDR_WIN);
    assign pend_we = win_we && (idx_q == IDXW'(PEND_IDX));
    assign stat_we = wr_fire && (host_addr == ADDR_STAT);

    ireg_file #(.NREG(NREG), .IDXW(IDXW)) u_file (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (win_we),
        .widx     (idx_q),
        .wdata    (host_wdata),
        .ridx     (idx_q),
        .rdata    (win_rdata),
        .cfg_flat (cfg_image)
    );

    ireg_irq_merge u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       ({src_tmr_done, src_cap_done, src_pb_done}),
        .clr_all   (stat_we),
        .mask_we   (pend_we),
        .keep_mask (host_wdata[NUM_SRC-1:0]),
        .ien       (cfg_image[PINCTL_IDX*DATA_W]),
        .pend      (pend_w),
        .int_flag  (int_flag)
    );

    always_comb begin
        unique case (host_addr)
            ADDR_PTR:  host_rdata = {{(DATA_W-IDXW){1'b0}}, idx_q};
            ADDR_WIN:  host_rdata = (idx_q == IDXW'(PEND_IDX))
                                    ? {{(DATA_W-NUM_SRC){1'b0}}, pend_w}
                                    : win_rdata;
            ADDR_STAT: host_rdata = {{(DATA_W-NUM_SRC-1){1'b0}}, pend_w, int_flag};
            ADDR_PIO:  host_rdata = cap_data;
            default:   host_rdata = '0;
        endcase
    end

    assign pb_data  = host_wdata;
    assign pb_valid = wr_fire && (host_addr == ADDR_PIO);
    assign cap_take = rd_fire && (host_addr == ADDR_PIO);
    assign irq      = int_flag;

endmodule

// File: rtl/ireg_host_port_chk.sv
module ireg_host_port_chk #(
    parameter int unsigned NREG = 37,
    parameter int unsigned IDXW = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      host_addr,
    input logic            host_wr,
    input logic            host_rd,
    input logic [7:0]      host_rdata,
    input logic            pb_valid,
    input logic            cap_take,
    input logic            irq,
    input logic            ien,
    input logic [2:0]      pend,
    input logic [IDXW-1:0] idx,
    input logic            src_pb,
    input logic            src_tmr,
    input logic            take_wr
);

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien && pend != 3'b000)); // R8

    AST_PB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pb_valid |=> !pb_valid); // R6

    AST_CAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_take |=> !cap_take); // R6

    AST_PB_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        pb_valid |-> (host_wr && host_addr == 2'd3)); // R5

    AST_CAP_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_take |-> (host_rd && !host_wr && host_addr == 2'd3)); // R5

    AST_BAD_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == 2'd1 && idx >= IDXW'(NREG)) |-> host_rdata == 8'h00); // R4

    AST_SRC_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        src_pb |=> pend[0]); // R11

    AST_TMR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        src_tmr |=> pend[2]); // R7

    AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (take_wr && host_addr == 2'd2 && !src_pb && !src_tmr) |=> (!pend[0] && !pend[2])); // R10

endmodule

bind ireg_host_port ireg_host_port_chk #(.NREG(NREG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .pb_valid   (pb_valid),
    .cap_take   (cap_take),
    .irq        (irq),
    .ien        (cfg_image[0]),
    .pend       (pend_w),
    .idx        (idx_q),
    .src_pb     (src_pb_done),
    .src_tmr    (src_tmr_done),
    .take_wr    (wr_fire)
);

// File: tb/ireg_host_port_bench.sv
`timescale 1ns/1ps
module ireg_host_port_bench;

    localparam int NREG = 37;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      host_addr = '0;
    logic [7:0]      host_wdata = '0;
    logic            host_wr = 1'b0;
    logic            host_rd = 1'b0;
    logic [7:0]      host_rdata;
    logic [7:0]      pb_data;
    logic            pb_valid;
    logic [7:0]      cap_data = 8'h00;
    logic            cap_take;
    logic            src_pb_done = 1'b0;
    logic            src_cap_done = 1'b0;
    logic            src_tmr_done = 1'b0;
    logic            irq;
    logic [NREG*8-1:0] cfg_image;

    int checks = 0;
    int failures = 0;
    int pb_cnt = 0;
    int cap_cnt = 0;
    logic [7:0] pb_last = '0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    ireg_host_port #(.NREG(NREG)) u_ireg_host_port (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .pb_data(pb_data), .pb_valid(pb_valid), .cap_data(cap_data), .cap_take(cap_take),
        .src_pb_done(src_pb_done), .src_cap_done(src_cap_done), .src_tmr_done(src_tmr_done),
        .irq(irq), .cfg_image(cfg_image)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected byte per read strobe and compares.
    always @(negedge clk) begin
        if (rst_n && pb_valid) begin
            pb_cnt++;
            pb_last = pb_data;
        end
        if (rst_n && cap_take) cap_cnt++;
        if (rst_n && host_rd) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "read with no expected item", host_rdata, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(host_rdata == e, t, host_rdata, e);
            end
        end
    end

    task automatic do_write(input logic [1:0] a, input logic [7:0] d, input int len);
        @(posedge clk); #1;
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        repeat (len) @(posedge clk);
        #1 host_wr = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        host_addr = a; host_rd = 1'b1;
        @(posedge clk); #1 host_rd = 1'b0;
    endtask

    task automatic pulse_src(input logic pb, input logic cp, input logic tm);
        @(posedge clk); #1;
        src_pb_done = pb; src_cap_done = cp; src_tmr_done = tm;
        @(posedge clk); #1;
        src_pb_done = 1'b0; src_cap_done = 1'b0; src_tmr_done = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string t);
        @(negedge clk);
        check(irq == e, t, irq, e);
    endtask

    task automatic set_reg(input logic [7:0] idx, input logic [7:0] d);
        do_write(2'd0, idx, 1);
        do_write(2'd1, d, 1);
    endtask

    initial begin
        int p0;
        int c0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check_irq(1'b0, "R1 irq after reset");
        @(negedge clk);
        check(cfg_image == '0, "R1 register image after reset", cfg_image[7:0], 0);
        do_read(2'd0, 8'h00, "R1 pointer after reset");
        do_read(2'd2, 8'h00, "R1 status after reset");

        // R2 pointer width
        do_write(2'd0, 8'hC5, 1);
        do_read(2'd0, 8'h05, "R2 pointer keeps low six bits");

        // R3 and R12 storage
        set_reg(8'd7, 8'hA5);
        @(negedge clk);
        check(cfg_image[7*8 +: 8] == 8'hA5, "R12 image updated after write", cfg_image[7*8 +: 8], 8'hA5);
        set_reg(8'd20, 8'h3C);
        set_reg(8'd36, 8'h99);
        do_write(2'd0, 8'd7, 1);
        do_read(2'd1, 8'hA5, "R3 index 7 readback");
        do_write(2'd0, 8'd36, 1);
        do_read(2'd1, 8'h99, "R3 last index readback");
        set_reg(8'd2, 8'h11);
        set_reg(8'd2, 8'h77);
        @(negedge clk);
        check(cfg_image[2*8 +: 8] == 8'h77, "R12 rewrite without lock", cfg_image[2*8 +: 8], 8'h77);

        // R4 out of range index
        set_reg(8'd40, 8'hFF);
        do_read(2'd1, 8'h00, "R4 index 40 reads zero");
        do_read(2'd0, 8'h28, "R4 pointer holds 40");
        @(negedge clk);
        check(cfg_image[36*8 +: 8] == 8'h99 && cfg_image[7*8 +: 8] == 8'hA5,
              "R4 out-of-range write changed nothing", cfg_image[36*8 +: 8], 8'h99);

        // R5 and R6 data port
        p0 = pb_cnt;
        do_write(2'd3, 8'h5A, 1);
        @(negedge clk);
        check(pb_cnt == p0 + 1 && pb_last == 8'h5A, "R5 playback byte", pb_last, 8'h5A);
        p0 = pb_cnt;
        do_write(2'd3, 8'hC3, 4);
        @(negedge clk);
        check(pb_cnt == p0 + 1, "R6 long strobe single pulse", pb_cnt - p0, 1);
        check(pb_last == 8'hC3, "R6 long strobe byte", pb_last, 8'hC3);
        c0 = cap_cnt;
        cap_data = 8'h6E;
        do_read(2'd3, 8'h6E, "R5 capture byte");
        @(negedge clk);
        check(cap_cnt == c0 + 1, "R5 capture take pulse", cap_cnt - c0, 1);

        // R7 pending without enable
        pulse_src(1'b1, 1'b0, 1'b0);
        check_irq(1'b0, "R7 no irq while disabled");
        do_read(2'd2, 8'h02, "R7 status shows playback pending");

        // R8 enable
        set_reg(8'd0, 8'h01);
        check_irq(1'b1, "R8 irq with enable");
        do_read(2'd2, 8'h03, "R8 status INT bit");
        pulse_src(1'b0, 1'b1, 1'b0);
        do_read(2'd2, 8'h07, "R8 status two pending");

        // R9 selective clear
        do_write(2'd0, 8'd1, 1);
        do_read(2'd1, 8'h03, "R7 pending register bits");
        do_write(2'd1, 8'hFE, 1);
        do_read(2'd1, 8'h02, "R9 playback cleared");
        do_write(2'd1, 8'hFF, 1);
        do_read(2'd1, 8'h02, "R9 ones leave pending");
        check_irq(1'b1, "R9 irq held by capture");
        do_write(2'd1, 8'hFD, 1);
        check_irq(1'b0, "R9 irq low after last clear");

        // R10 status write
        pulse_src(1'b1, 1'b0, 1'b1);
        do_read(2'd2, 8'h0B, "R7 timer and playback pending");
        do_write(2'd2, 8'h00, 1);
        check_irq(1'b0, "R10 status write clears");
        do_read(2'd1, 8'h00, "R10 pending empty");

        // R11 set beats clear
        @(posedge clk); #1;
        host_addr = 2'd2; host_wdata = 8'h00; host_wr = 1'b1; src_tmr_done = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0; src_tmr_done = 1'b0;
        do_read(2'd2, 8'h09, "R11 timer survives clear");
        check_irq(1'b1, "R11 irq stays");

        repeat (3) @(posedge clk);
        check(exp_q.size() == 0, "all expected reads consumed", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule